// File: doc/BRIEF.md
# Switching Clock Synchronization Controller

This block produces the cycle-start timing for a fixed-frequency switching power converter. Each switching cycle begins with a one-clock pulse on `cyc_start`. A two-bit mode input picks the source of that timing. In the primary mode the block runs free at a programmed period, counted in system clock cycles, and drives a square synchronization output that other converters can follow. In the two secondary modes it follows an external synchronization clock and starts each cycle on either its rising or its falling edge.

In a secondary mode the block watches the external clock and reacts when it goes missing. It first runs at a reduced transition frequency, 0.7 times nominal, for a programmable number of clock cycles. After that it returns to the programmed free-running period. When a usable external edge comes back, the block locks to it again. The raw sync input passes through a two-flop synchronizer before its edges are detected.

Top module: `swclk_sync`

## Requirements
- R1: While `rst` is high, `cyc_start`, `sync_out`, `sync_oe`, `locked`, `sync_lost` and `in_trans` all read 0.
- R2: When not locked, `cyc_start` pulses every P clock cycles, where P is `period` (values below 4 count as 4). The mode codes are: 00 primary, 01 lock to the rising edge, 10 and 11 lock to the falling edge. After reset the first pulse comes P cycles after `rst` falls.
- R3: In primary mode, `sync_out` is low for floor(P/2) cycles, starting with the cycle in which `cyc_start` is high, and high for the rest of the period. Its falling edge coincides with `cyc_start`.
- R4: In mode 01, `cyc_start` rises on the third rising edge of `clk` after `sync_in` rises. While locked, the interval between pulses equals the external sync period.
- R5: In modes 10 and 11, the same alignment and period tracking as in R4 apply to the falling edge of `sync_in`.
- R6: While locked, a selected edge seen fewer than ceil(10P/13) cycles after the last cycle start is ignored and starts no cycle.
- R7: While locked, if no accepted edge arrives, a cycle starts floor(3P/2) cycles after the previous one. In that same cycle `sync_lost` and `in_trans` go high and `locked` goes low.
- R8: During the transition, `cyc_start` pulses every ceil(10P/7) cycles.
- R9: `in_trans` clears exactly TRANS_CYC cycles after it was set. The period then returns to P, and `sync_lost` stays high.
- R10: In a secondary mode, when the block is not locked, the first selected edge starts a cycle at once (same 3-cycle latency as in R4). It also sets `locked` and clears `sync_lost`.
- R11: In primary mode `sync_oe` is 1, and `sync_in` edges have no effect on timing. In the secondary modes `sync_oe` and `sync_out` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 2 | Timing source select (00 primary, 01 rising, 10/11 falling) |
| period | input | PW | Programmed free-running period in clock cycles |
| sync_in | input | 1 | Raw external synchronization clock |
| cyc_start | output | 1 | One-cycle pulse at the start of each switching cycle |
| sync_out | output | 1 | Square synchronization output (primary mode) |
| sync_oe | output | 1 | Enable for the synchronization output driver |
| locked | output | 1 | Cycle starts follow the external clock |
| sync_lost | output | 1 | External clock was lost and has not returned |
| in_trans | output | 1 | Reduced-frequency transition interval in progress |

## Verification
A corrupted timing state shows up directly as a wrong interval between `cyc_start` pulses. For example, a stuck lock state gives a 1.5P gap instead of the sync period, and a wrong fallback state gives a P or ceil(10P/7) spacing in the wrong place. All of these are visible within two switching periods. Flag errors show in the same cycle as the pulse that should move them. Examples are `sync_lost` failing to rise with the timeout pulse, or `in_trans` outliving its TRANS_CYC window. A broken edge path shows as a cycle start that is not exactly three clocks after the chosen sync edge.

// File: rtl/swsync_pkg.sv
package swsync_pkg;
  typedef enum logic [1:0] {
    TS_FREE  = 2'd0,
    TS_LOCK  = 2'd1,
    TS_TRANS = 2'd2
  } time_state_e;

  localparam logic [1:0] MODE_PRIMARY = 2'b00;

  function automatic logic mode_is_primary(input logic [1:0] m);
    return m == MODE_PRIMARY;
  endfunction

  // codes 10 and 11 both select the falling edge
  function automatic logic mode_uses_fall(input logic [1:0] m);
    return m[1];
  endfunction
endpackage

// File: rtl/swsync_edge.sv
module swsync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic rise,
  output logic fall
);
  // chain[STAGES-1] is the synchronized level, chain[STAGES] its previous value
  logic [STAGES:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[STAGES-1:0], din};
  end

  assign rise = chain[STAGES-1] & ~chain[STAGES];
  assign fall = ~chain[STAGES-1] & chain[STAGES];
endmodule

// File: rtl/swsync_limits.sv
module swsync_limits #(
  parameter int PW = 12,
  parameter int CW = PW + 1
) (
  input  logic          clk,
  input  logic [PW-1:0] period,
  output logic [CW-1:0] half_m1,
  output logic [CW-1:0] free_end,
  output logic [CW-1:0] loss_end,
  output logic [CW-1:0] trans_end,
  output logic [CW-1:0] win_min
);
  localparam int MIN_PER = 4;
  localparam int XW      = PW + 5;

  logic [XW-1:0] p_x;
  logic [XW-1:0] p10;

  always_comb begin
    p_x = (period < PW'(MIN_PER)) ? XW'(MIN_PER) : XW'(period);
    p10 = (p_x << 3) + (p_x << 1);
  end

  // No reset: these follow the period input continuously, so they are valid
  // before reset is released and the constant dividers stay off the loop path.
  always_ff @(posedge clk) begin
    half_m1   <= CW'((p_x >> 1) - XW'(1));
    free_end  <= CW'(p_x - XW'(1));
    loss_end  <= CW'(p_x + (p_x >> 1) - XW'(1));
    trans_end <= CW'((p10 + XW'(6)) / XW'(7) - XW'(1));
    win_min   <= CW'((p10 + XW'(12)) / XW'(13));
  end
endmodule

// File: rtl/swsync_core.sv
module swsync_core
  import swsync_pkg::*;
#(
  parameter int CW        = 13,
  parameter int TRANS_CYC = 1000
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [1:0]    mode,
  input  logic          rise,
  input  logic          fall,
  input  logic [CW-1:0] half_m1,
  input  logic [CW-1:0] free_end,
  input  logic [CW-1:0] loss_end,
  input  logic [CW-1:0] trans_end,
  input  logic [CW-1:0] win_min,
  output logic          cyc_start,
  output logic          sync_out,
  output logic          sync_oe,
  output logic          locked,
  output logic          sync_lost,
  output logic          in_trans
);
  localparam int            TW      = $clog2(TRANS_CYC + 1);
  localparam logic [CW-1:0] CNT_MAX = {CW{1'b1}};
  localparam logic [TW-1:0] TMR_MAX = {TW{1'b1}};
  localparam logic [TW-1:0] TMR_END = TW'(TRANS_CYC - 1);

  time_state_e   st_q, st_n;
  logic [CW-1:0] cnt_q;
  logic [TW-1:0] tmr_q;
  logic [CW-1:0] end_sel;
  logic          primary, sel_edge, edge_ok, end_hit, start_now, lost_n;

  always_comb begin
    primary  = mode_is_primary(mode);
    sel_edge = mode_uses_fall(mode) ? fall : rise;
    // the early-edge window only guards an established lock
    edge_ok  = !primary && sel_edge && ((st_q != TS_LOCK) || (cnt_q >= win_min));
    unique case (st_q)
      TS_LOCK:  end_sel = loss_end;
      TS_TRANS: end_sel = trans_end;
      default:  end_sel = free_end;
    endcase
    end_hit   = cnt_q >= end_sel;
    start_now = edge_ok || end_hit;

    st_n   = st_q;
    lost_n = sync_lost;
    if (primary) begin
      st_n   = TS_FREE;
      lost_n = 1'b0;
    end else if (edge_ok) begin
      st_n   = TS_LOCK;
      lost_n = 1'b0;
    end else if (st_q == TS_LOCK && end_hit) begin
      st_n   = TS_TRANS;
      lost_n = 1'b1;
    end else if (st_q == TS_TRANS && tmr_q >= TMR_END) begin
      st_n   = TS_FREE;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= TS_FREE;
      cnt_q     <= '0;
      tmr_q     <= '0;
      cyc_start <= 1'b0;
      sync_out  <= 1'b0;
      sync_oe   <= 1'b0;
      locked    <= 1'b0;
      sync_lost <= 1'b0;
      in_trans  <= 1'b0;
    end else begin
      st_q      <= st_n;
      cyc_start <= start_now;
      cnt_q     <= start_now ? '0 : ((cnt_q == CNT_MAX) ? cnt_q : cnt_q + 1'b1);
      if (st_n == TS_TRANS && st_q == TS_TRANS)
        tmr_q <= (tmr_q == TMR_MAX) ? tmr_q : tmr_q + 1'b1;
      else
        tmr_q <= '0;
      locked    <= (st_n == TS_LOCK);
      in_trans  <= (st_n == TS_TRANS);
      sync_lost <= lost_n;
      sync_oe   <= primary;
      if (!primary || start_now) sync_out <= 1'b0;
      else if (cnt_q == half_m1) sync_out <= 1'b1;
    end
  end

  // R9: the transition only exists after a loss
  p_trans_has_loss_r9: assert property (@(posedge clk) disable iff (rst)
    in_trans |-> sync_lost);

  // R7: entering the transition is marked by the timeout cycle start
  p_enter_trans_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(in_trans) |-> (cyc_start && !locked));

  // R3: the sync output only falls at a cycle start while it is driven
  p_fall_at_start_r3: assert property (@(posedge clk) disable iff (rst)
    ($fell(sync_out) && sync_oe) |-> cyc_start);

  // R11: an undriven sync output stays low
  p_quiet_secondary_r11: assert property (@(posedge clk) disable iff (rst)
    !sync_oe |-> !sync_out);

  // R10: acquiring lock starts a cycle and clears the loss flag
  p_relock_r10: assert property (@(posedge clk) disable iff (rst)
    $rose(locked) |-> (cyc_start && !sync_lost));

  // R6: a locked cycle start is never followed straight by another
  p_no_early_restart_r6: assert property (@(posedge clk) disable iff (rst)
    (locked && cyc_start) |=> !cyc_start);
endmodule

// File: rtl/swclk_sync.sv
module swclk_sync #(
  parameter int PW          = 12,
  parameter int TRANS_CYC   = 1000,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [1:0]    mode,
  input  logic [PW-1:0] period,
  input  logic          sync_in,
  output logic          cyc_start,
  output logic          sync_out,
  output logic          sync_oe,
  output logic          locked,
  output logic          sync_lost,
  output logic          in_trans
);
  localparam int CW = PW + 1;

  logic          rise, fall;
  logic [CW-1:0] half_m1, free_end, loss_end, trans_end, win_min;

  swsync_edge #(.STAGES(SYNC_STAGES)) u_edge (
    .clk  (clk),
    .rst  (rst),
    .din  (sync_in),
    .rise (rise),
    .fall (fall)
  );

  swsync_limits #(.PW(PW), .CW(CW)) u_limits (
    .clk       (clk),
    .period    (period),
    .half_m1   (half_m1),
    .free_end  (free_end),
    .loss_end  (loss_end),
    .trans_end (trans_end),
    .win_min   (win_min)
  );

  swsync_core #(.CW(CW), .TRANS_CYC(TRANS_CYC)) u_core (
    .clk       (clk),
    .rst       (rst),
    .mode      (mode),
    .rise      (rise),
    .fall      (fall),
    .half_m1   (half_m1),
    .free_end  (free_end),
    .loss_end  (loss_end),
    .trans_end (trans_end),
    .win_min   (win_min),
    .cyc_start (cyc_start),
    .sync_out  (sync_out),
    .sync_oe   (sync_oe),
    .locked    (locked),
    .sync_lost (sync_lost),
    .in_trans  (in_trans)
  );
endmodule

// File: tb/swclk_sync_bench.sv
module swclk_sync_bench;
  localparam int PW = 12;
  localparam int TC = 300;
  localparam int P  = 40;
  localparam int NV = 9;
  // fields: mode[17:16], sync period[15:8] (0 = no sync), expected interval[7:0]
  localparam logic [17:0] VEC [0:NV-1] = '{
    {2'd0, 8'd0,  8'd40},
    {2'd0, 8'd33, 8'd40},
    {2'd1, 8'd40, 8'd40},
    {2'd1, 8'd32, 8'd32},
    {2'd1, 8'd56, 8'd56},
    {2'd2, 8'd40, 8'd40},
    {2'd2, 8'd50, 8'd50},
    {2'd3, 8'd44, 8'd44},
    {2'd1, 8'd48, 8'd48}
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [1:0]    mode = 2'd0;
  logic [PW-1:0] period = PW'(P);
  logic          sync_in = 1'b0;
  logic          cyc_start, sync_out, sync_oe, locked, sync_lost, in_trans;

  swclk_sync #(.PW(PW), .TRANS_CYC(TC), .SYNC_STAGES(2)) u_swclk_sync (
    .clk(clk), .rst(rst), .mode(mode), .period(period), .sync_in(sync_in),
    .cyc_start(cyc_start), .sync_out(sync_out), .sync_oe(sync_oe),
    .locked(locked), .sync_lost(sync_lost), .in_trans(in_trans)
  );

  always #10 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0;
  int fails  = 0;

  // external sync clock generator
  logic gen_en = 1'b0;
  int   gen_t = 40;
  int   sph = 0;
  int   rise_cyc = 0;
  int   fall_cyc = 0;
  always @(negedge clk) begin
    if (gen_en) begin
      if (sph == 0) begin sync_in = 1'b1; rise_cyc = cyc; end
      else if (sph == gen_t / 2) begin sync_in = 1'b0; fall_cyc = cyc; end
      sph = (sph >= gen_t - 1) ? 0 : sph + 1;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_start(output int t);
    t = -100000;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (cyc_start) begin t = cyc; break; end
    end
  endtask

  task automatic do_reset(input logic [1:0] m);
    gen_en  = 1'b0;
    sync_in = 1'b0;
    mode    = m;
    rst     = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    int t0, t1, t2, tx, lo, hi, ref_c, iv;
    logic [1:0] m;
    int tp, ex;
    string lbl;

    // R1: reset state
    mode = 2'd0;
    rst  = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 cyc_start", cyc_start, 0);
    chk("R1 sync_out", sync_out, 0);
    chk("R1 sync_oe", sync_oe, 0);
    chk("R1 flags", {29'd0, locked, sync_lost, in_trans}, 0);
    rst = 1'b0;

    // R2: first free pulse P cycles after reset release
    tx = cyc;
    wait_start(t0);
    chk("R2 first pulse", t0 - tx, P);

    // vector table walk
    for (int v = 0; v < NV; v++) begin
      m  = VEC[v][17:16];
      tp = int'(VEC[v][15:8]);
      ex = int'(VEC[v][7:0]);
      do_reset(m);
      if (tp != 0) begin gen_t = tp; sph = 0; gen_en = 1'b1; end
      repeat (10 * ((tp > ex) ? tp : ex)) @(negedge clk);
      if (m == 2'd0) lbl = (tp == 0) ? "R2" : "R11";
      else if (m == 2'd1) lbl = "R4";
      else lbl = "R5";
      wait_start(t0);
      if (m != 2'd0) begin
        ref_c = (m == 2'd1) ? rise_cyc : fall_cyc;
        chk({lbl, " edge alignment"}, t0 - ref_c, 3);
      end
      wait_start(t1);
      chk({lbl, " interval"}, t1 - t0, ex);
      chk({lbl, " locked"}, locked, (m != 2'd0) ? 1 : 0);
      chk("R11 sync_oe", sync_oe, (m == 2'd0) ? 1 : 0);
      if (m != 2'd0) chk("R11 sync_out quiet", sync_out, 0);
      gen_en = 1'b0;
    end

    // R3: primary square wave shape
    do_reset(2'd0);
    wait_start(t0);
    chk("R3 low at start", sync_out, 0);
    lo = 0;
    while (sync_out == 1'b0 && lo < 200) begin lo++; @(negedge clk); end
    hi = 0;
    while (sync_out == 1'b1 && hi < 200) begin hi++; @(negedge clk); end
    chk("R3 low time", lo, P / 2);
    chk("R3 high time", hi, P - P / 2);
    chk("R3 fall with start", cyc_start, 1);

    // R6/R7/R8/R9/R10: loss, transition, fallback and relock
    do_reset(2'd1);
    gen_t = 40; sph = 0; gen_en = 1'b1;
    repeat (400) @(negedge clk);
    wait_start(t0);
    gen_en = 1'b0;
    sync_in = 1'b0;
    repeat (10) @(negedge clk);
    sync_in = 1'b1;            // early rising edge, must be ignored
    repeat (3) @(negedge clk);
    sync_in = 1'b0;
    wait_start(t1);
    chk("R6 early edge ignored / R7 timeout", t1 - t0, (3 * P) / 2);
    chk("R7 sync_lost", sync_lost, 1);
    chk("R7 in_trans", in_trans, 1);
    chk("R7 locked", locked, 0);
    wait_start(t2);
    chk("R8 transition period", t2 - t1, (10 * P + 6) / 7);
    tx = -1;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (!in_trans) begin tx = cyc; break; end
    end
    chk("R9 transition length", tx - t1, TC);
    wait_start(t0);
    wait_start(t1);
    chk("R9 back to nominal", t1 - t0, P);
    chk("R9 sync_lost held", sync_lost, 1);
    gen_t = 44; sph = 0; gen_en = 1'b1;
    wait_start(t0);
    iv = t0 - rise_cyc;
    chk("R10 acquire latency", iv, 3);
    chk("R10 locked", locked, 1);
    chk("R10 sync_lost cleared", sync_lost, 0);
    wait_start(t1);
    chk("R10 tracked interval", t1 - t0, 44);
    gen_en = 1'b0;

    finish_run();
  end
endmodule